// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Front End

This block sits between an interrupt distributor and one processor core. The distributor offers its single best candidate for the core: an ID, a priority, the number of the core that raised it (for software-generated IDs) and whether it is edge-triggered. The block decides whether that candidate may interrupt the core. A candidate qualifies when its ID is a real interrupt, its priority beats the core's threshold and delivery is switched on. The block then drives the core's request line.

Software uses four word registers:
- address 0: control, where bit 0 enables delivery.
- address 1: threshold, in bits 7:0.
- address 2: acknowledge, read-only.
- address 3: end of interrupt, write-only.

Reading the acknowledge register claims the offered interrupt. The block pulses an activation strobe so the distributor can mark that interrupt active, and clears its pending state if it is edge-triggered. Writing the claimed value back to the end-of-interrupt register releases it, and the block pulses a completion strobe toward the distributor. The block tracks one active interrupt at a time.

Top module: `cpu_ack_if`

## Requirements
- R1: After reset the request line is low, the control and threshold registers read 0, and no interrupt is active.
- R2: Bit 0 of the control register (address 0) gates the request line: with it 0 no request is raised whatever the candidate. The bit reads back at bit 0.
- R3: The threshold (address 1, bits 7:0) lets only candidates whose priority value is strictly below it raise a request. A priority equal to the threshold does not.
- R4: A candidate ID of 1020 or more never raises a request and is never acknowledged; an acknowledge read then returns 1023.
- R5: An acknowledge read (address 2) of a qualifying candidate returns its ID in bits 9:0. For IDs 0 to 15 it also returns the requesting core number in bits 12:10. For IDs of 16 and above those bits are 0.
- R6: When nothing qualifies, an acknowledge read returns 1023, pulses no activation strobe and changes no state.
- R7: A successful acknowledge pulses the activation strobe for one cycle with the claimed ID and source. The pending-clear strobe pulses with it only for an edge-triggered candidate.
- R8: While an interrupt is active, the request line stays low and acknowledge reads return 1023.
- R9: An end-of-interrupt write (address 3) carrying the acknowledged value ends the active state. It pulses the completion strobe with that ID for one cycle, and a qualifying candidate raises the request again.
- R10: An end-of-interrupt write whose ID differs from the active one is ignored, as is one for an ID below 16 whose bits 12:10 differ from the active source. No completion pulse follows and the request stays low.
- R11: Read data is registered: it changes on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_src | input | 3 | Requesting core of a software-generated candidate |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_edge | input | 1 | Candidate is edge-triggered |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the core |
| act_set_o | output | 1 | Pulse: mark claimed interrupt active |
| pend_clr_o | output | 1 | Pulse: clear pending of claimed edge interrupt |
| act_id_o | output | 10 | ID of the claimed interrupt |
| act_src_o | output | 3 | Source core of the claimed interrupt |
| eoi_o | output | 1 | Pulse: active interrupt completed |
| eoi_id_o | output | 10 | ID of the completed interrupt |
| eoi_src_o | output | 3 | Source core of the completed interrupt |

## Verification
The bench builds the block with its default widths: a 10-bit ID, a 3-bit source field and an 8-bit priority. These put the reserved boundary at 1019/1020, the spurious value 1023, and the software/peripheral split at 15/16 within direct reach. Threshold tests cover a priority equal to the threshold and one just below it. The end-of-interrupt tests use the SGI source bits to show that a value matching the ID alone does not release a software-generated interrupt.

// File: rtl/cpu_ack_if.sv
module cpu_ack_if #(
  parameter int ID_W        = 10,
  parameter int SRC_W       = 3,
  parameter int PRIO_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_SGI     = 16,
  parameter int FIRST_RSVD  = 1020,
  parameter int SPURIOUS_ID = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [SRC_W-1:0]  cand_src,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              cand_edge,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o,
  output logic              act_set_o,
  output logic              pend_clr_o,
  output logic [ID_W-1:0]   act_id_o,
  output logic [SRC_W-1:0]  act_src_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o,
  output logic [SRC_W-1:0]  eoi_src_o
);

  localparam int ACK_W = ID_W + SRC_W;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_ACK  = 2'd2;
  localparam logic [1:0] A_EOI  = 2'd3;
  localparam logic [ID_W-1:0] RSVD_ID = ID_W'(FIRST_RSVD);
  localparam logic [ID_W-1:0] SGI_END = ID_W'(NUM_SGI);
  localparam logic [ID_W-1:0] SPUR    = ID_W'(SPURIOUS_ID);

  logic              en_q;
  logic [PRIO_W-1:0] mask_q;
  logic              busy_q;
  logic [ID_W-1:0]   cur_id_q;
  logic [SRC_W-1:0]  cur_src_q;

  logic              qual, grant, ack_rd, take, eoi_wr, eoi_hit;
  logic [ID_W-1:0]   w_id;
  logic [SRC_W-1:0]  w_src, src_fld;
  logic [ACK_W-1:0]  ack_val;
  logic [DATA_W-1:0] rd_next;

  assign qual    = cand_valid && (cand_id < RSVD_ID) && (cand_prio < mask_q);
  assign grant   = en_q && qual && !busy_q;
  assign irq_o   = grant;

  assign ack_rd  = reg_re && (reg_addr == A_ACK);
  assign take    = ack_rd && grant;
  assign src_fld = (cand_id < SGI_END) ? cand_src : '0;
  assign ack_val = take ? {src_fld, cand_id} : {{SRC_W{1'b0}}, SPUR};

  assign eoi_wr  = reg_we && (reg_addr == A_EOI);
  assign w_id    = reg_wdata[ID_W-1:0];
  assign w_src   = reg_wdata[ID_W +: SRC_W];
  assign eoi_hit = eoi_wr && busy_q && (w_id == cur_id_q) &&
                   ((cur_id_q >= SGI_END) || (w_src == cur_src_q));

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_CTRL:  rd_next[0] = en_q;
      A_MASK:  rd_next[PRIO_W-1:0] = mask_q;
      A_ACK:   rd_next[ACK_W-1:0] = ack_val;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) en_q <= reg_wdata[0];
      if (reg_addr == A_MASK) mask_q <= reg_wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_id_q  <= '0;
      cur_src_q <= '0;
    end else if (take) begin
      busy_q    <= 1'b1;
      cur_id_q  <= cand_id;
      cur_src_q <= src_fld;
    end else if (eoi_hit) begin
      busy_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      act_set_o  <= 1'b0;
      pend_clr_o <= 1'b0;
      act_id_o   <= '0;
      act_src_o  <= '0;
      eoi_o      <= 1'b0;
      eoi_id_o   <= '0;
      eoi_src_o  <= '0;
    end else begin
      if (reg_re) reg_rdata <= rd_next;
      act_set_o  <= take;
      pend_clr_o <= take && cand_edge;
      if (take) begin
        act_id_o  <= cand_id;
        act_src_o <= src_fld;
      end
      eoi_o <= eoi_hit;
      if (eoi_hit) begin
        eoi_id_o  <= cur_id_q;
        eoi_src_o <= cur_src_q;
      end
    end
  end

  p_claim_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_o |-> $past(irq_o));
  p_edge_clear_with_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> act_set_o);
  p_quiet_after_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_o |-> !irq_o);
  p_claim_id_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_o |-> (act_id_o < RSVD_ID));
  p_claim_returns_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_set_o |-> (reg_rdata[ACK_W-1:0] == {act_src_o, act_id_o}));
  p_spurious_no_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_set_o == 1'b0 && $past(ack_rd)) |-> (reg_rdata[ID_W-1:0] == SPUR));
  p_eoi_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_o |-> ($past(reg_we) && $past(reg_addr) == A_EOI));

endmodule

// File: tb/test_cpu_ack_if.sv
module test_cpu_ack_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [2:0]  cand_src = '0;
  logic [7:0]  cand_prio = '0;
  logic        cand_edge = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, act_set_o, pend_clr_o, eoi_o;
  logic [9:0]  act_id_o, eoi_id_o;
  logic [2:0]  act_src_o, eoi_src_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] rd_v;
  logic        set_v, clr_v, eoi_v;
  logic [9:0]  aid_v, eid_v;

  always #2 clk = ~clk;

  cpu_ack_if i_cpu_ack_if (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_src(cand_src), .cand_prio(cand_prio), .cand_edge(cand_edge),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .act_set_o(act_set_o),
    .pend_clr_o(pend_clr_o), .act_id_o(act_id_o), .act_src_o(act_src_o),
    .eoi_o(eoi_o), .eoi_id_o(eoi_id_o), .eoi_src_o(eoi_src_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
    eoi_v = eoi_o; eid_v = eoi_id_o;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0;
    rd_v = reg_rdata; set_v = act_set_o; clr_v = pend_clr_o; aid_v = act_id_o;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [2:0] s,
                       input logic [7:0] p, input logic e);
    @(negedge clk); cand_valid = v; cand_id = id; cand_src = s; cand_prio = p; cand_edge = e;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_o, 0);
    rd(2'd0); chk("R1 ctrl", rd_v, 0);
    rd(2'd1); chk("R1 mask", rd_v, 0);
    offer(1, 10'd40, 0, 8'h00, 0);
    wr(2'd0, 1);
    #1 chk("R1 mask 0 blocks", irq_o, 0);
    wr(2'd0, 0);
  endtask

  task automatic t_enable;
    wr(2'd1, 32'hF0);
    offer(1, 10'd40, 0, 8'h80, 0);
    chk("R2 disabled", irq_o, 0);
    wr(2'd0, 1); #1 chk("R2 enabled", irq_o, 1);
    rd(2'd0); chk("R2 readback", rd_v, 1);
    wr(2'd0, 0); #1 chk("R2 off again", irq_o, 0);
    wr(2'd0, 1);
  endtask

  task automatic t_mask;
    offer(1, 10'd40, 0, 8'hF0, 0); chk("R3 equal prio", irq_o, 0);
    offer(1, 10'd40, 0, 8'hEF, 0); chk("R3 below", irq_o, 1);
    rd(2'd1); chk("R3 readback", rd_v, 32'hF0);
  endtask

  task automatic t_reserved;
    offer(1, 10'd1020, 0, 8'h00, 0); chk("R4 1020 irq", irq_o, 0);
    rd(2'd2); chk("R4 ack spurious", rd_v, 1023); chk("R4 no claim", set_v, 0);
    offer(1, 10'd1019, 0, 8'h00, 0); chk("R4 1019 irq", irq_o, 1);
  endtask

  task automatic t_ppi;
    offer(1, 10'd20, 3'd5, 8'h10, 0);
    rd(2'd2);
    chk("R5 ppi value", rd_v, 20);
    chk("R7 act_set", set_v, 1); chk("R7 act_id", aid_v, 20); chk("R7 level no clr", clr_v, 0);
    chk("R8 irq low", irq_o, 0);
    @(negedge clk); chk("R7 one pulse", act_set_o, 0);
    rd(2'd2); chk("R8 ack spurious", rd_v, 1023); chk("R8 no claim", set_v, 0);
    wr(2'd3, 21); chk("R10 wrong id", eoi_v, 0); #1 chk("R10 irq low", irq_o, 0);
    wr(2'd3, 20); chk("R9 eoi", eoi_v, 1); chk("R9 eoi id", eid_v, 20);
    #1 chk("R9 irq again", irq_o, 1);
  endtask

  task automatic t_sgi;
    offer(1, 10'd3, 3'd6, 8'h10, 1);
    rd(2'd2);
    chk("R5 sgi value", rd_v, 32'h1803); chk("R7 edge clr", clr_v, 1);
    wr(2'd3, 3); chk("R10 src mismatch", eoi_v, 0); #1 chk("R10 irq", irq_o, 0);
    wr(2'd3, 32'h1803); chk("R9 sgi eoi", eoi_v, 1); chk("R9 sgi id", eid_v, 3);
  endtask

  task automatic t_spurious;
    offer(0, 10'd50, 0, 8'h10, 0);
    rd(2'd2); chk("R6 value", rd_v, 1023); chk("R6 no claim", set_v, 0);
    offer(1, 10'd50, 0, 8'h10, 0); chk("R6 state kept", irq_o, 1);
  endtask

  task automatic t_latency;
    rd(2'd1);
    @(negedge clk); reg_re = 1'b1; reg_addr = 2'd0; #1;
    chk("R11 before edge", reg_rdata, 32'hF0);
    @(negedge clk); reg_re = 1'b0;
    chk("R11 after edge", reg_rdata, 1);
    @(negedge clk); chk("R11 hold", reg_rdata, 1);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_enable;
    t_mask;
    t_reserved;
    t_ppi;
    t_sgi;
    t_spurious;
    t_latency;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule